// File: doc/BRIEF.md
# Single-Edge TCK Edge-Enable Synchronizer

This block sits on the target side of a test access port. The chip it serves clocks every flip-flop on the rising edge of one system clock. The block brings the asynchronous TCK, TMS and TDI pins into that clock domain through a chain of flip-flops. It finds each TCK transition and turns it into a single-cycle clock enable, one for rising edges and one for falling edges. The TAP state machine then advances on these enables and never uses TCK as a clock.

The block also returns a TCK echo, `rtck_o`, to the debug probe, and it re-times the TAP's serial output into `tdo_o`. Both outputs move only in the cycle after an enable, so they follow TCK with a fixed delay. A probe that uses adaptive clocking waits for the echo before it makes the next TCK transition. That handshake keeps the port from running faster than the synchronizer, which means no TCK transition can be lost. Test reset `trst_n` clears the block at once, and its release is synchronized to the system clock.

None of the pins carries a data stream, so every pin is a plain level signal with no valid/ready handshake. Back-pressure is applied only through the echo, which the probe must honour.

Top module: `tck_edge_sync`

## Requirements
- R1: While `trst_n` is 0, `rtck_o`, `tdo_o`, both enables, `tap_tms_o` and `tap_tdi_o` read 0 no later than 1 ns after `trst_n` falls, without waiting for a clock edge. They stay 0 until the synchronized release.
- R2: Suppose `tck` changes from 0 to 1 between two rising edges of `clk`, and call the next rising edge edge 1. Then `tck_rise_en_o` is 1 after edge 3 and 0 after edges 1, 2, 4 and 5. That is exactly one cycle.
- R3: A 1-to-0 change of `tck` makes `tck_fall_en_o` 1 after edge 3 only, counted the same way as in R2.
- R4: The two enables are never 1 in the same cycle. A rising enable never appears for a falling TCK change, and a falling enable never appears for a rising one.
- R5: After a `tck` change, `rtck_o` takes the new TCK level at edge 4, and keeps its old level after edges 1 to 3. The delay from the TCK change to the echo is therefore 3 to 4 `clk` periods. `rtck_o` changes only in the cycle after an enable.
- R6: `tdo_o` loads `tdo_core_i` at the edge after `tck_fall_en_o`, which is edge 4 of a falling TCK change. It keeps its value through a rising TCK change, whatever `tdo_core_i` holds.
- R7: `tap_tms_o` and `tap_tdi_o` take the synchronized `tms` and `tdi` levels in the same cycle in which `tck_rise_en_o` rises. They hold those values through a falling TCK change even if `tms` and `tdi` change.
- R8: `tms` and `tdi` pass through as many synchronizing stages as `tck`. Levels set up before a TCK rising change are therefore the ones captured for that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every flip-flop uses its rising edge |
| trst_n | input | 1 | Test reset, active low; assertion takes effect at once, release is synchronized |
| tck | input | 1 | Test clock from the probe, asynchronous to `clk` |
| tms | input | 1 | Test mode select from the probe, asynchronous |
| tdi | input | 1 | Test data in from the probe, asynchronous |
| tdo_core_i | input | 1 | Raw serial output of the TAP logic |
| tck_rise_en_o | output | 1 | One-cycle enable for each TCK rising edge |
| tck_fall_en_o | output | 1 | One-cycle enable for each TCK falling edge |
| tap_tms_o | output | 1 | TMS captured for the TAP on the rising enable |
| tap_tdi_o | output | 1 | TDI captured for the TAP on the rising enable |
| rtck_o | output | 1 | TCK echo to the probe for adaptive clocking |
| tdo_o | output | 1 | Re-timed test data out to the probe |

## Verification
Suppose the delayed TCK copy or one of the synchronizer stages holds the wrong level. The fault shows within four `clk` edges of the next TCK change: an enable is missing, an extra enable appears, or the echo does not arrive. A probe using adaptive clocking would then stall. A stale retiming register shows on `tdo_o` or `tap_tms_o` as a value from a previous TCK cycle at edge 4 or edge 3. The bench sweeps every phase of the TCK change within the clock period, and every combination of TMS, TDI and TDO levels. Each cycle is compared against the edge counts stated in the requirements.

// File: rtl/tck_sync_pkg.sv
package tck_sync_pkg;

  // Bundle of asynchronous probe pins that share one synchronizer chain.
  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
  } probe_pins_t;

  localparam int PROBE_W = $bits(probe_pins_t);

  // Clock edges from a TCK change to the matching enable (counting the
  // capture edge as the first): stages plus the edge-detect register.
  function automatic int enable_edge(input int stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/tck_rst_sync.sv
module tck_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic trst_n,
  output logic rst_n_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] shf;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) shf <= '0;
        else         shf <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) shf <= '0;
        else         shf <= {shf[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = shf[LAST];

  // R1: the release never shows up before the test reset itself is released
  a_r1_release_after_trst: assert property (@(posedge clk)
    rst_n_o |-> trst_n);

endmodule

// File: rtl/tck_pin_sync.sv
module tck_pin_sync
  import tck_sync_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  probe_pins_t pins_i,
  output probe_pins_t pins_o
);

  localparam int LAST = STAGES - 1;

  probe_pins_t chain [STAGES];

  // R8: one chain of equal depth for TCK, TMS and TDI
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= pins_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pins_o = chain[LAST];

  // R8: the last stage only ever takes what the stage before it held
  generate
    if (STAGES > 1) begin : g_chk
      a_r8_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
        (chain[LAST] != $past(chain[LAST])) |-> (chain[LAST] == $past(chain[LAST-1])));
    end
  endgenerate

endmodule

// File: rtl/tck_edge_gen.sv
module tck_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_s,
  input  logic tms_s,
  input  logic tdi_s,
  output logic rise_en_o,
  output logic fall_en_o,
  output logic tms_q_o,
  output logic tdi_q_o
);

  logic tck_prev;
  logic rise_det;
  logic fall_det;

  assign rise_det = tck_s & ~tck_prev;
  assign fall_det = ~tck_s & tck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_prev  <= 1'b0;
      rise_en_o <= 1'b0;
      fall_en_o <= 1'b0;
      tms_q_o   <= 1'b0;
      tdi_q_o   <= 1'b0;
    end else begin
      tck_prev  <= tck_s;
      rise_en_o <= rise_det;
      fall_en_o <= fall_det;
      if (rise_det) begin
        tms_q_o <= tms_s;
        tdi_q_o <= tdi_s;
      end
    end
  end

  a_r2_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rise_en_o |=> !rise_en_o);
  a_r3_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fall_en_o |=> !fall_en_o);
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_en_o && fall_en_o));
  a_r7_tms_moves_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (tms_q_o != $past(tms_q_o)) |-> rise_en_o);
  a_r7_tdi_moves_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (tdi_q_o != $past(tdi_q_o)) |-> rise_en_o);

endmodule

// File: rtl/tck_retimer.sv
module tck_retimer (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_en,
  input  logic fall_en,
  input  logic tdo_core,
  output logic rtck_o,
  output logic tdo_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtck_o <= 1'b0;
      tdo_o  <= 1'b0;
    end else begin
      if (rise_en)      rtck_o <= 1'b1;
      else if (fall_en) rtck_o <= 1'b0;
      if (fall_en)      tdo_o  <= tdo_core;
    end
  end

  a_r5_echo_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_en |=> rtck_o);
  a_r5_echo_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall_en |=> !rtck_o);
  a_r5_echo_only_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (rtck_o != $past(rtck_o)) |-> $past(rise_en || fall_en));
  a_r6_tdo_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (tdo_o != $past(tdo_o)) |-> $past(fall_en));

endmodule

// File: rtl/tck_edge_sync.sv
module tck_edge_sync
  import tck_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic trst_n,
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic tdo_core_i,
  output logic tck_rise_en_o,
  output logic tck_fall_en_o,
  output logic tap_tms_o,
  output logic tap_tdi_o,
  output logic rtck_o,
  output logic tdo_o
);

  localparam int EN_EDGE = enable_edge(SYNC_STAGES);

  logic        rst_n;
  probe_pins_t raw_pins;
  probe_pins_t sync_pins;
  logic        rise_en;
  logic        fall_en;

  initial begin
    if (SYNC_STAGES < 1 || RST_STAGES < 1 || EN_EDGE != SYNC_STAGES + 1)
      $error("tck_edge_sync: stage counts must be at least one");
  end

  assign raw_pins = '{tck: tck, tms: tms, tdi: tdi};

  tck_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .trst_n  (trst_n),
    .rst_n_o (rst_n)
  );

  tck_pin_sync #(.STAGES(SYNC_STAGES)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (raw_pins),
    .pins_o (sync_pins)
  );

  tck_edge_gen u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tck_s     (sync_pins.tck),
    .tms_s     (sync_pins.tms),
    .tdi_s     (sync_pins.tdi),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .tms_q_o   (tap_tms_o),
    .tdi_q_o   (tap_tdi_o)
  );

  tck_retimer u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .tdo_core (tdo_core_i),
    .rtck_o   (rtck_o),
    .tdo_o    (tdo_o)
  );

  assign tck_rise_en_o = rise_en;
  assign tck_fall_en_o = fall_en;

  // R1: outputs are quiet whenever the test reset pin is low
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !trst_n |-> !(rtck_o || tdo_o || tck_rise_en_o || tck_fall_en_o));

endmodule

// File: tb/sim_tck_edge_sync.sv
module sim_tck_edge_sync;

  localparam int CLK_PERIOD = 10;
  localparam int EN_AT      = 3;
  localparam int ECHO_AT    = 4;

  logic clk = 1'b0;
  logic trst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b0, tdi = 1'b0, tdo_core = 1'b0;
  logic rise_en, fall_en, tap_tms, tap_tdi, rtck, tdo;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tck_edge_sync u0 (
    .clk(clk), .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .tdo_core_i(tdo_core), .tck_rise_en_o(rise_en), .tck_fall_en_o(fall_en),
    .tap_tms_o(tap_tms), .tap_tdi_o(tap_tdi), .rtck_o(rtck), .tdo_o(tdo)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one TCK change at offset off after a rising edge, then observe
  // five edges and compare against the edge counts in R2..R7.
  task automatic tck_step(input int off, input logic lvl,
                          input logic old_tms, input logic new_tms,
                          input logic old_tdi, input logic new_tdi,
                          input logic old_tdo, input logic new_tdo);
    @(posedge clk);
    #off;
    tck = lvl;
    for (int e = 1; e <= 5; e++) begin
      @(posedge clk);
      #1;
      if (lvl) begin
        chk("R2 rise enable", rise_en, e == EN_AT);
        chk("R4 no fall on rise", fall_en, 1'b0);
        chk("R7 tms capture", tap_tms, (e >= EN_AT) ? new_tms : old_tms);
        chk("R8 tdi capture", tap_tdi, (e >= EN_AT) ? new_tdi : old_tdi);
        chk("R6 tdo held on rise", tdo, old_tdo);
      end else begin
        chk("R3 fall enable", fall_en, e == EN_AT);
        chk("R4 no rise on fall", rise_en, 1'b0);
        chk("R7 tms held on fall", tap_tms, old_tms);
        chk("R7 tdi held on fall", tap_tdi, old_tdi);
        chk("R6 tdo load on fall", tdo, (e >= ECHO_AT) ? new_tdo : old_tdo);
      end
      chk("R5 echo latency", rtck, (e >= ECHO_AT) ? lvl : ~lvl);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic cur_tms, cur_tdi, cur_tdo;
    cur_tms = 0; cur_tdi = 0; cur_tdo = 0;
    tck = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rtck", rtck, 1'b0);
    chk("R1 reset tdo", tdo, 1'b0);
    chk("R1 reset rise", rise_en, 1'b0);
    chk("R1 reset tms", tap_tms, 1'b0);
    tck = 1'b0;
    @(negedge clk);
    trst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R1 idle after release", rtck | rise_en | fall_en, 1'b0);

    for (int off = 1; off < CLK_PERIOD; off++) begin
      for (int v = 0; v < 8; v++) begin
        logic ntms, ntdi, ntdo;
        ntms = v[0]; ntdi = v[1]; ntdo = v[2];
        tms = ntms; tdi = ntdi;
        tdo_core = ~cur_tdo;
        tck_step(off, 1'b1, cur_tms, ntms, cur_tdi, ntdi, cur_tdo, cur_tdo);
        cur_tms = ntms; cur_tdi = ntdi;
        tms = ~ntms; tdi = ~ntdi;
        tdo_core = ntdo;
        tck_step(CLK_PERIOD - off, 1'b0, cur_tms, cur_tms, cur_tdi, cur_tdi,
                 cur_tdo, ntdo);
        cur_tdo = ntdo;
      end
    end

    // Reset in the middle of a TCK high phase with the echo and TDO at 1
    tms = 1; tdi = 1; tdo_core = 1;
    tck_step(4, 1'b1, cur_tms, 1'b1, cur_tdi, 1'b1, cur_tdo, cur_tdo);
    tck_step(4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, cur_tdo, 1'b1);
    tck_step(4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    @(posedge clk);
    #3;
    trst_n = 1'b0;
    #1;
    chk("R1 async clear rtck", rtck, 1'b0);
    chk("R1 async clear tdo", tdo, 1'b0);
    chk("R1 async clear tms", tap_tms, 1'b0);
    chk("R1 async clear tdi", tap_tdi, 1'b0);
    tck = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    trst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R1 stays clear", rtck | tdo | rise_en | fall_en, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule